// File: doc/BRIEF.md
# Auto-Restart Fault Timer

This block watches for a sustained output fault in a switching regulator and limits the stress while the fault lasts. A counter advances on each switching-oscillator tick. It starts again from zero whenever the feedback comparator reports a level above the restart threshold. If the feedback stays low for a full timeout, the switch-enable gate closes. The block then runs a repeating pattern of a long disabled window followed by a short enabled window.

During an enabled window, a tick that sees the feedback above the threshold ends the fault. The block returns to normal operation with its counter cleared. A disabled window always runs its full length. All durations are parameters counted in oscillator ticks. The defaults give a 3-tick on window against a 22-tick off window, which is a 12% on-duty cycle. The default timeout is 14500 ticks, close to 145 ms at 100 kHz.

Top module: `fault_restart_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `sw_enable` is 1 and the block is in normal operation with its count at zero.
- R2: State and count change only on clock edges where `osc_tick` is 1. Input changes between ticks have no effect on `sw_enable`.
- R3: In normal operation, a tick with `fb_above` = 1 clears the count. A fault is declared only after TIMEOUT_TICKS ticks in a row with `fb_above` = 0.
- R4: On the edge of the TIMEOUT_TICKS-th consecutive low-feedback tick, `sw_enable` goes to 0.
- R5: The disabled window lasts exactly OFF_TICKS ticks, and `fb_above` has no effect during it.
- R6: After the disabled window, `sw_enable` is 1 for ON_TICKS ticks. If every one of those ticks sees `fb_above` = 0, a new disabled window starts.
- R7: A tick with `fb_above` = 1 during an enabled restart window returns the block to normal operation with the count cleared. A later fault again needs a full TIMEOUT_TICKS low ticks.
- R8: The off/on restart pattern repeats with no limit while the feedback stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | One-cycle pulse per switching-oscillator cycle |
| fb_above | input | 1 | 1 when the feedback level is above the restart threshold |
| sw_enable | output | 1 | 1 allows switching, 0 blocks it |

## Verification
The block is driven with feedback held low while no ticks arrive. This separates tick gating from plain cycle counting. It is then driven with low runs that stop one tick short of the timeout before a single high tick, which shows that the count is cleared and not merely paused. Feedback is toggled high during disabled windows to confirm that they always run their full length. Feedback is raised on one tick of an enabled window, followed by a fresh low run, to show that recovery clears the count and a second fault needs the whole timeout again. Ticks arrive every cycle in some phases and sparsely in others, so that ticks and clock cycles cannot be confused.

// File: rtl/fault_restart_timer.sv
module fault_restart_timer #(
  parameter int TIMEOUT_TICKS = 14500,
  parameter int ON_TICKS      = 3,
  parameter int OFF_TICKS     = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic fb_above,
  output logic sw_enable
);
  localparam int MAXT = (TIMEOUT_TICKS > OFF_TICKS) ?
                        ((TIMEOUT_TICKS > ON_TICKS) ? TIMEOUT_TICKS : ON_TICKS) :
                        ((OFF_TICKS > ON_TICKS) ? OFF_TICKS : ON_TICKS);
  localparam int CW = $clog2(MAXT + 1);
  localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT_TICKS - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_REST = 2'd1, ST_TRY = 2'd2} state_t;

  state_t        state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      cnt   <= '0;
    end else if (osc_tick) begin
      case (state)
        ST_RUN: begin
          if (fb_above)            cnt <= '0;
          else if (cnt == TO_LAST) begin state <= ST_REST; cnt <= '0; end
          else                     cnt <= cnt + 1'b1;
        end
        ST_REST: begin
          if (cnt == OFF_LAST) begin state <= ST_TRY; cnt <= '0; end
          else                 cnt <= cnt + 1'b1;
        end
        ST_TRY: begin
          if (fb_above)            begin state <= ST_RUN;  cnt <= '0; end
          else if (cnt == ON_LAST) begin state <= ST_REST; cnt <= '0; end
          else                     cnt <= cnt + 1'b1;
        end
        default: begin state <= ST_RUN; cnt <= '0; end
      endcase
    end
  end

  assign sw_enable = (state != ST_REST);
endmodule

module fault_restart_timer_chk #(
  parameter int TIMEOUT_TICKS = 14500,
  parameter int ON_TICKS      = 3,
  parameter int OFF_TICKS     = 22,
  parameter int CW            = 14,
  parameter int MAXT          = 14500
) (
  input logic          clk,
  input logic          rst_n,
  input logic          osc_tick,
  input logic          fb_above,
  input logic          sw_enable,
  input logic [1:0]    st,
  input logic [CW-1:0] cnt
);
  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (st == 2'd0 && cnt == '0 && sw_enable));
  // R2
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> ($stable(st) && $stable(cnt)));
  // R3
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && osc_tick && fb_above) |=> (st == 2'd0 && cnt == '0));
  // R4
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_enable) |-> ($past(osc_tick) && !$past(fb_above)));
  // R5
  rest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && osc_tick && cnt != CW'(OFF_TICKS - 1)) |=> (st == 2'd1 && !sw_enable));
  // R6
  rise_try_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_enable) |-> st == 2'd2);
  // R7
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && osc_tick && fb_above) |=> (st == 2'd0 && cnt == '0 && sw_enable));
  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < CW'(MAXT) && st != 2'd3));
endmodule

bind fault_restart_timer fault_restart_timer_chk #(
  .TIMEOUT_TICKS(TIMEOUT_TICKS), .ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS),
  .CW(CW), .MAXT(MAXT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .fb_above(fb_above),
  .sw_enable(sw_enable), .st(state), .cnt(cnt)
);

// File: tb/fault_restart_timer_tb.sv
module fault_restart_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO  = 20;
  localparam int ONT = 3;
  localparam int OFT = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic fb_above = 1'b1;
  logic sw_enable;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  int m_mode = 0;
  int m_cnt = 0;

  fault_restart_timer #(.TIMEOUT_TICKS(TO), .ON_TICKS(ONT), .OFF_TICKS(OFT)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .fb_above(fb_above), .sw_enable(sw_enable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0;
    end else if (osc_tick) begin
      if (m_mode == 0) begin
        if (fb_above) m_cnt = 0;
        else begin
          m_cnt++;
          if (m_cnt == TO) begin m_mode = 1; m_cnt = 0; end
        end
      end else if (m_mode == 1) begin
        m_cnt++;
        if (m_cnt == OFT) begin m_mode = 2; m_cnt = 0; end
      end else begin
        if (fb_above) begin m_mode = 0; m_cnt = 0; end
        else begin
          m_cnt++;
          if (m_cnt == ONT) begin m_mode = 1; m_cnt = 0; end
        end
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sw_enable=%0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check(cur_req, sw_enable, (m_mode != 1));
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected under 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic t, input logic f);
    osc_tick = t; fb_above = f;
    @(posedge clk); #1;
  endtask

  int n;

  initial begin
    #(CLK_PERIOD/4);
    repeat (3) @(posedge clk);
    #1;
    check("R1", sw_enable, 1'b1);
    rst_n = 1'b1;
    step(1, 0);
    check("R1", sw_enable, 1'b1);

    cur_req = "R2";
    for (int i = 0; i < 60; i++) step(0, 0);
    check("R2", sw_enable, 1'b1);
    for (int i = 0; i < 30; i++) step((i % 3) == 0, (i % 2) == 0);

    cur_req = "R3";
    step(1, 1);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < TO - 1; i++) begin step(1, 0); step(0, 1); end
      step(1, 1);
    end
    check("R3", sw_enable, 1'b1);

    cur_req = "R4";
    for (int i = 0; i < TO - 1; i++) step(1, 0);
    check("R4", sw_enable, 1'b1);
    step(1, 0);
    check("R4", sw_enable, 1'b0);

    cur_req = "R5";
    n = 1;
    for (int i = 0; i < 200 && sw_enable == 1'b0; i++) begin
      step(1, (i % 2) == 0);
      if (sw_enable == 1'b0) n++;
    end
    if (n != OFT) begin errors++; $display("FAIL R5: off window %0d ticks expected %0d", n, OFT); end
    checks++;

    cur_req = "R6";
    n = 1;
    for (int i = 0; i < 50 && sw_enable == 1'b1; i++) begin
      step(1, 0);
      if (sw_enable == 1'b1) n++;
    end
    if (n != ONT) begin errors++; $display("FAIL R6: on window %0d ticks expected %0d", n, ONT); end
    checks++;

    cur_req = "R8";
    for (int i = 0; i < 4 * (ONT + OFT); i++) step(1, 0);
    for (int i = 0; i < 40; i++) step((i % 4) == 0, 0);

    cur_req = "R7";
    for (int i = 0; i < 200 && sw_enable == 1'b0; i++) step(1, 0);
    check("R7", sw_enable, 1'b1);
    step(1, 1);
    for (int i = 0; i < TO - 1; i++) step(1, 0);
    check("R7", sw_enable, 1'b1);
    step(1, 0);
    check("R7", sw_enable, 1'b0);
    for (int i = 0; i < 200 && sw_enable == 1'b0; i++) step(1, 1);
    step(0, 1);
    step(1, 1);
    for (int i = 0; i < 10; i++) step(1, 1);
    check("R7", sw_enable, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule